// File: doc/BRIEF.md
# Memory Fill Engine

This block writes one 64-bit pattern to every doubleword of a memory region. Software loads a start address, a byte count and the two 32-bit halves of the pattern through a small register write port. It then sets a start bit. The engine puts one 64-bit write beat at a time on a valid/ready write channel, from the start address upward, until the whole region is covered. It then drops its busy flag and raises a one-cycle completion pulse.

A start request is checked before any traffic is issued. The byte count must lie inside a parameterised window and must be a whole number of doublewords. The start address must be doubleword aligned. The engine must also be idle. A request that fails any of these checks is dropped without effect. The address, the count and the pattern are captured at the moment a start is accepted, so software may prepare the next fill while the current one runs.

Top module: `fill_engine`

## Requirements
- R1: While reset is held, and on the first cycle after reset is released, `busy`, `wr_valid` and `done` are low.
- R2: The register port decodes `cfg_sel` as follows: 0 is the start address, 1 is the byte count, 2 is pattern bits 31:0, 3 is pattern bits 63:32, and 4 is control, whose bit 0 requests a start. A write with any other select value changes nothing. A control write with bit 0 clear does not start a fill.
- R3: An accepted start raises `busy` and `wr_valid` on the next cycle, with `wr_addr` equal to the start address.
- R4: Every beat carries `wr_data` equal to {pattern high half, pattern low half}.
- R5: A beat is accepted only in a cycle where `wr_valid` and `wr_ready` are both high. Each accepted beat advances `wr_addr` by 8. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R6: A fill issues exactly byte count / 8 accepted beats.
- R7: After the last beat is accepted, `busy` and `wr_valid` are low on the next cycle, and `done` is high for exactly that one cycle.
- R8: A byte count below MIN_BYTES or above MAX_BYTES is refused. Both bounds themselves are accepted. A refused start issues no beat and leaves `busy` low.
- R9: A start address with any of bits 2:0 set, or a byte count with any of bits 2:0 set, is refused. No beat is issued.
- R10: A start request while `busy` is high is ignored. The running fill keeps its addresses and its beat count.
- R11: Register writes made while a fill is running do not change the addresses, data or count of that fill. They do take effect for the next fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted by memory |
| wr_addr | output | AW | Byte address of the beat |
| wr_data | output | 64 | Pattern data of the beat |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench tests both bounds of the size window and the sizes just outside them. A design with an off-by-one compare would either refuse a legal fill or write to memory for an illegal one. Misaligned addresses and counts are tried, because a design that truncated them would silently write the wrong region. Backpressure is random, so a design that advanced on valid alone would skip addresses or issue too many beats. The bench also injects a start and a pattern write part-way through a run. A design without a captured copy would restart, or change its data in the middle of the fill.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [2:0] {
    SEL_PTR  = 3'd0,
    SEL_SIZE = 3'd1,
    SEL_LO   = 3'd2,
    SEL_HI   = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  localparam int unsigned BEAT_BYTES = 8;
  localparam int unsigned BEAT_SHIFT = 3;

  // byte count inside [lo_lim, hi_lim], both ends inclusive
  function automatic logic size_in_window(input logic [31:0] sz,
                                          input logic [31:0] lo_lim,
                                          input logic [31:0] hi_lim);
    return (sz >= lo_lim) && (sz <= hi_lim);
  endfunction

  // low three bits clear
  function automatic logic dword_aligned(input logic [31:0] v);
    return v[2:0] == 3'b000;
  endfunction

  function automatic logic [31:0] beats_of(input logic [31:0] sz);
    return sz >> BEAT_SHIFT;
  endfunction

endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [AW-1:0] dest_q,
  output logic [31:0]   size_q,
  output logic [63:0]   pat_q,
  output logic          start_req
);

  logic [31:0] pat_lo_q;
  logic [31:0] pat_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q   <= '0;
      size_q   <= '0;
      pat_lo_q <= '0;
      pat_hi_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_PTR:  dest_q   <= AW'(cfg_wdata);
        SEL_SIZE: size_q   <= cfg_wdata;
        SEL_LO:   pat_lo_q <= cfg_wdata;
        SEL_HI:   pat_hi_q <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  assign pat_q     = {pat_hi_q, pat_lo_q};
  assign start_req = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];

endmodule

// File: rtl/fill_req_check.sv
module fill_req_check
  import fill_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MIN_BYTES = 128,
  parameter int MAX_BYTES = 16777216
) (
  input  logic [AW-1:0] dest,
  input  logic [31:0]   size,
  input  logic          start_req,
  input  logic          busy,
  output logic          start_accept
);

  localparam logic [31:0] LO_LIM = 32'(MIN_BYTES);
  localparam logic [31:0] HI_LIM = 32'(MAX_BYTES);

  logic range_ok;
  logic align_ok;

  always_comb begin
    range_ok     = size_in_window(size, LO_LIM, HI_LIM);
    align_ok     = (dest[2:0] == 3'b000) && dword_aligned(size);
    start_accept = start_req && !busy && range_ok && align_ok;
  end

endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer #(
  parameter int AW    = 32,
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_accept,
  input  logic [AW-1:0]    dest,
  input  logic [CNT_W-1:0] beats,
  input  logic [63:0]      pattern,
  input  logic             wr_ready,
  output logic             busy,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [63:0]      wr_data,
  output logic             done,
  output logic             last_beat
);

  logic [CNT_W-1:0] left_q;
  logic [AW-1:0]    addr_q;
  logic [63:0]      pat_q;
  logic             busy_q;
  logic             done_q;
  logic             take;

  assign take      = busy_q && wr_ready;
  assign last_beat = take && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      pat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_accept) begin
        busy_q <= 1'b1;
        left_q <= beats;
        addr_q <= dest;
        pat_q  <= pattern;
      end else if (take) begin
        addr_q <= addr_q + AW'(8);
        left_q <= left_q - CNT_W'(1);
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign wr_valid = busy_q;
  assign wr_addr  = addr_q;
  assign wr_data  = pat_q;
  assign done     = done_q;

endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MIN_BYTES = 128,
  parameter int MAX_BYTES = 16777216
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic          busy,
  output logic          done
);

  localparam int MAX_BEATS = MAX_BYTES / BEAT_BYTES;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  logic [AW-1:0]    dest_q;
  logic [31:0]      size_q;
  logic [63:0]      pat_q;
  logic             start_req;
  logic             start_accept;
  logic             last_beat;
  logic [CNT_W-1:0] beat_cnt;

  assign beat_cnt = CNT_W'(beats_of(size_q));

  fill_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .dest_q    (dest_q),
    .size_q    (size_q),
    .pat_q     (pat_q),
    .start_req (start_req)
  );

  fill_req_check #(.AW(AW), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) u_check (
    .dest         (dest_q),
    .size         (size_q),
    .start_req    (start_req),
    .busy         (busy),
    .start_accept (start_accept)
  );

  fill_sequencer #(.AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_accept (start_accept),
    .dest         (dest_q),
    .beats        (beat_cnt),
    .pattern      (pat_q),
    .wr_ready     (wr_ready),
    .busy         (busy),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .done         (done),
    .last_beat    (last_beat)
  );

endmodule

// File: rtl/fill_engine_sva.sv
module fill_engine_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [63:0]   wr_data,
  input logic          start_accept,
  input logic          last_beat
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !busy && !wr_valid && !done);

  p_start_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy && (wr_addr[2:0] == 3'b000));

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_accept) |=> !busy || $stable(wr_data));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !last_beat) |=> wr_addr == $past(wr_addr) + AW'(8));

  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done && !busy && !wr_valid);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |-> !busy);

endmodule

bind fill_engine fill_engine_sva #(.AW(AW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .start_accept (start_accept),
  .last_beat    (last_beat)
);

// File: tb/fill_engine_bench.sv
module fill_engine_bench;

  localparam int AW   = 32;
  localparam int MINB = 128;
  localparam int MAXB = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;
  logic          busy;
  logic          done;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  logic [31:0] m_ptr, m_size, m_lo, m_hi;

  always #5 clk = ~clk;

  fill_engine #(.AW(AW), .MIN_BYTES(MINB), .MAX_BYTES(MAXB)) u_fill_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_ok(input logic [31:0] p, input logic [31:0] s);
    return (s >= MINB) && (s <= MAXB) && (s % 8 == 0) && (p % 8 == 0);
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_ptr = d;
      3'd1: m_size = d;
      3'd2: m_lo = d;
      3'd3: m_hi = d;
      default: ;
    endcase
  endtask

  // start and follow one fill; inj_at < 0 means no write during the run
  task automatic run_fill(input string tag, input bit rnd_ready,
                          input int inj_at, input logic [2:0] inj_sel,
                          input logic [31:0] inj_d);
    logic [31:0] p, s;
    logic [63:0] pat;
    int beats;
    int n;
    bit inj_on;
    p = m_ptr; s = m_size; pat = {m_hi, m_lo};
    beats = 0; n = 0; inj_on = 0;
    cfg_write(3'd4, 32'h1);
    if (!exp_ok(p, s)) begin
      for (int k = 0; k < 4; k++) begin
        chk({tag, " R8/R9 refused busy"}, busy, 0);
        chk({tag, " R8/R9 refused no beat"}, wr_valid, 0);
        @(negedge clk);
      end
      return;
    end
    chk({tag, " R3 busy after start"}, busy, 1);
    while (n < 20000) begin
      if (inj_on) begin cfg_we = 1'b0; inj_on = 0; end
      if (!wr_valid) break;
      chk({tag, " R5 addr"}, wr_addr, 64'(p + 32'(beats * 8)));
      chk({tag, " R4/R11 data"}, wr_data, pat);
      if (beats == inj_at && !inj_on && inj_at >= 0) begin
        cfg_we = 1'b1; cfg_sel = inj_sel; cfg_wdata = inj_d; inj_on = 1;
        inj_at = -1;
        if (inj_sel == 3'd2) m_lo = inj_d;
        if (inj_sel == 3'd3) m_hi = inj_d;
      end
      wr_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
      if (wr_ready) beats = beats + 1;
      @(negedge clk);
      n = n + 1;
    end
    cfg_we = 1'b0;
    wr_ready = 1'b0;
    chk({tag, " R6 beat count"}, 64'(beats), 64'(s / 8));
    chk({tag, " R7 done high"}, done, 1);
    chk({tag, " R7 busy low"}, busy, 0);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0; wr_ready = 1'b0;
    m_ptr = 0; m_size = 0; m_lo = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 busy after reset", busy, 0);

    // R2 minimum size, always ready
    cfg_write(3'd0, 32'h0000_1000);
    cfg_write(3'd1, 32'd128);
    cfg_write(3'd2, 32'hDEAD_BEEF);
    cfg_write(3'd3, 32'h0123_4567);
    run_fill("min", 0, -1, 3'd0, 0);
    // R8 maximum size, random backpressure
    cfg_write(3'd1, MAXB);
    run_fill("max", 1, -1, 3'd0, 0);
    // R8 just outside bounds
    cfg_write(3'd1, MINB - 8);
    run_fill("below", 0, -1, 3'd0, 0);
    cfg_write(3'd1, MAXB + 8);
    run_fill("above", 0, -1, 3'd0, 0);
    // R9 misalignment
    cfg_write(3'd1, 32'd256);
    cfg_write(3'd0, 32'h0000_2004);
    run_fill("ptr_mis", 0, -1, 3'd0, 0);
    cfg_write(3'd0, 32'h0000_2000);
    cfg_write(3'd1, 32'd260);
    run_fill("size_mis", 0, -1, 3'd0, 0);
    // R2 unused selects and start bit clear
    cfg_write(3'd1, 32'd256);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    chk("R2 sel5 no start", busy, 0);
    cfg_write(3'd7, 32'h1);
    chk("R2 sel7 no start", busy, 0);
    cfg_write(3'd4, 32'h0);
    chk("R2 ctrl bit0 clear no start", busy, 0);
    // R10 start while busy
    run_fill("restart", 1, 3, 3'd4, 32'h1);
    // R11 pattern write mid-run, then used next run
    run_fill("midwr", 0, 2, 3'd2, 32'hCAFE_F00D);
    run_fill("next", 0, -1, 3'd0, 0);

    // random runs
    for (int r = 0; r < 20; r++) begin
      logic [31:0] sz;
      sz = 32'($urandom_range(MINB / 8, 256 / 8 * 4)) * 8;
      if (sz > MAXB) sz = MAXB;
      cfg_write(3'd0, {$urandom_range(0, 32'h0FFF_FFFF), 3'b000});
      cfg_write(3'd1, sz);
      cfg_write(3'd2, $urandom);
      cfg_write(3'd3, $urandom);
      run_fill("rand", 1, -1, 3'd0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule